// File: doc/BRIEF.md
# Quadrature Numerically Controlled Oscillator

This block turns a programmable frequency word into a pair of sine and cosine samples every clock. A 32-bit phase register grows by the frequency word on every cycle. A programmable phase offset is added to that phase, and the upper bits of the sum address a quarter-wave magnitude table. Quadrant logic rebuilds the whole period from that quarter. The frequency word for an output frequency f at clock rate fclk is f·2^32/fclk; at 100 MHz, 1 kHz is 0xA7C5 and 10 kHz is 0x68DB8.

The frequency word and the phase offset each arrive on their own 32-bit valid/data stream. A word is taken on any cycle where its valid is high, and there is no back-pressure. Two output streams leave the block: a packed sine/cosine sample word and the running phase register. A build parameter selects one of three variants. The full oscillator uses both parts. The phase-generator variant omits the table and drives only the phase stream. The table-only variant addresses the table straight from the phase input. A second build switch adds pseudo-random phase dither below the address bits, which spreads the truncation spurs.

Top module: `quad_nco`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following edge leaves the phase register, the frequency word and the offset at zero. The same edge leaves both valids low and both data outputs at zero.
- R2: The frequency word loads on any edge where `freq_valid` is high and holds otherwise. On each edge the phase register adds the word that was held before that edge. In the full and phase-generator variants, `phase_out_data` shows the phase register, and `phase_out_valid` is high from the first edge after reset release.
- R3: The phase offset loads on any edge where `offs_valid` is high and holds otherwise. The table address is bits 31:22 of (phase register + offset), taken modulo 2^32.
- R4: For a table address a, the sine byte at `out_data[15:8]` is round(127·sin(2π(a+0.5)/1024)) in two's complement. The cosine byte at `out_data[7:0]` uses address (a+256) mod 1024.
- R5: `out_valid` rises on the third edge after reset release and then stays high. The sample after edge k uses the phase register and offset held after edge k-2.
- R6: In the phase-generator variant, `out_valid` stays low and `out_data` stays zero, while the phase stream behaves as in R2.
- R7: In the table-only variant, the table address is bits 31:22 of the offset register alone, with the R5 timing. `phase_out_valid` stays low.
- R8: With dither enabled, a 16-bit LFSR adds its low 8 bits at bits 21:14 of the phase sum. Each sample pair then belongs to address a or a+1, where a is the undithered address. Both addresses occur over time, and the phase stream is unaffected.
- R9: Neither sample byte ever takes the value 0x80; full scale is ±127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_valid | input | 1 | Frequency word strobe |
| freq_data | input | 32 | Frequency word (phase step per clock) |
| offs_valid | input | 1 | Phase offset strobe |
| offs_data | input | 32 | Phase offset, or table phase in the table-only variant |
| out_valid | output | 1 | Sample stream valid |
| out_data | output | 16 | Sine in [15:8], cosine in [7:0], two's complement |
| phase_out_valid | output | 1 | Phase stream valid |
| phase_out_data | output | 32 | Running phase register |

## Verification
A frequency word that is strobed at edge t first shows on the phase stream after edge t+1 and reaches the samples after edge t+3. An offset strobed at edge t reaches the samples after edge t+2. The bench model keeps a two-entry address queue and a running phase, and these are updated at each rising edge from the inputs held across that edge. All outputs are compared at the following falling edge, so every expected value lines up with those latencies. The dither build is checked on a set of allowed values, since its exact sequence is not modelled.

// File: rtl/nco_pkg.sv
// Package: shared mode type and the quarter-wave magnitude generator.
// Assumes the table is computed at elaboration; sample magnitudes are unsigned.
package nco_pkg;

    typedef enum logic [1:0] {
        NCO_FULL       = 2'd0,
        NCO_PHASE_ONLY = 2'd1,
        NCO_TABLE_ONLY = 2'd2
    } nco_mode_e;

    localparam real HALF_PI = 1.5707963267948966;

    // Magnitude of entry idx of a quarter sine, sampled at bin centres.
    function automatic int quarter_mag(input int idx, input int depth, input int mag_w);
        real full;
        real x;
        full = real'((1 << mag_w) - 1);
        x    = full * $sin(HALF_PI * (real'(idx) + 0.5) / real'(depth));
        return $rtoi(x + 0.5);
    endfunction

endpackage

// File: rtl/nco_dither_lfsr.sv
// Module: Galois LFSR that supplies pseudo-random dither bits.
// Assumes a nonzero seed; the low OUT_W bits are taken each cycle.
module nco_dither_lfsr #(
    parameter int               LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS  = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED  = 16'hACE1,
    parameter int               OUT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] bits_o
);

    logic [LFSR_W-1:0] state_q;

    // Shift right, folding the tap mask in when a one leaves the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= {1'b0, state_q[LFSR_W-1:1]} ^ (state_q[0] ? TAPS : '0);
        end
    end

    assign bits_o = state_q[OUT_W-1:0];

endmodule

// File: rtl/nco_phase_acc.sv
// Module: frequency/offset registers, phase register, dither injection and
// the registered table address. Assumes both config strobes may be high on
// any cycle; a strobe with no data change is harmless.
module nco_phase_acc #(
    parameter int PHASE_W   = 32,
    parameter int ADDR_W    = 10,
    parameter int DITHER_W  = 8,
    parameter bit USE_ACC   = 1'b1,
    parameter bit DITHER_EN = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               freq_valid,
    input  logic [PHASE_W-1:0] freq_data,
    input  logic               offs_valid,
    input  logic [PHASE_W-1:0] offs_data,
    output logic [PHASE_W-1:0] acc_o,
    output logic [ADDR_W-1:0]  addr_o
);

    localparam int DSH = PHASE_W - ADDR_W - DITHER_W;

    logic [PHASE_W-1:0]  freq_q;
    logic [PHASE_W-1:0]  offs_q;
    logic [PHASE_W-1:0]  acc_q;
    logic [PHASE_W-1:0]  base;
    logic [PHASE_W-1:0]  dith_ext;
    logic [PHASE_W-1:0]  phase_sum;
    logic [DITHER_W-1:0] dith_bits;
    logic [ADDR_W-1:0]   addr_q;

    // Capture the configuration words when strobed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q <= '0;
            offs_q <= '0;
        end else begin
            if (freq_valid) freq_q <= freq_data;
            if (offs_valid) offs_q <= offs_data;
        end
    end

    // Phase register: steps by the held frequency word each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= USE_ACC ? acc_q + freq_q : '0;
        end
    end

    if (DITHER_EN) begin : g_dither
        nco_dither_lfsr #(.OUT_W(DITHER_W)) u_lfsr (
            .clk    (clk),
            .rst_n  (rst_n),
            .bits_o (dith_bits)
        );
    end else begin : g_no_dither
        assign dith_bits = '0;
    end

    // Dither sits just below the address bits so it moves the address by at most one.
    assign dith_ext  = PHASE_W'(dith_bits) << DSH;
    assign base      = USE_ACC ? acc_q : '0;
    assign phase_sum = base + offs_q + dith_ext;

    // Register the truncated table address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= phase_sum[PHASE_W-1 -: ADDR_W];
        end
    end

    assign acc_o  = acc_q;
    assign addr_o = addr_q;

endmodule

// File: rtl/nco_sincos_lut.sv
// Module: quarter-wave table with quadrant folding, producing a registered
// two's-complement sine/cosine pair. Assumes ADDR_W >= 3; cosine is the
// sine lookup shifted by a quarter period.
module nco_sincos_lut #(
    parameter int ADDR_W   = 10,
    parameter int SAMPLE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr_i,
    output logic [2*SAMPLE_W-1:0] sample_o
);

    localparam int QA_W   = ADDR_W - 2;
    localparam int QDEPTH = 1 << QA_W;
    localparam int MAG_W  = SAMPLE_W - 1;

    logic [MAG_W-1:0]    rom [QDEPTH];
    logic [SAMPLE_W-1:0] val [2];

    for (genvar g = 0; g < QDEPTH; g++) begin : g_rom
        assign rom[g] = MAG_W'(nco_pkg::quarter_mag(g, QDEPTH, MAG_W));
    end

    // Channel 0 is sine, channel 1 is cosine (address advanced by a quarter).
    for (genvar k = 0; k < 2; k++) begin : g_ch
        logic [ADDR_W-1:0] a;
        logic [QA_W-1:0]   idx;
        logic [MAG_W-1:0]  mag;
        assign a   = addr_i + ADDR_W'(k * QDEPTH);
        assign idx = a[ADDR_W-2] ? ~a[QA_W-1:0] : a[QA_W-1:0];
        assign mag = rom[idx];
        assign val[k] = a[ADDR_W-1] ? -{1'b0, mag} : {1'b0, mag};
    end

    // Register the packed pair, sine in the upper half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o <= '0;
        end else begin
            sample_o <= {val[0], val[1]};
        end
    end

endmodule

// File: rtl/quad_nco.sv
// Module: top of the quadrature oscillator. Selects the build variant,
// generates the fixed-latency valids and drives both output streams.
// Assumes a free-running single clock and synchronous active-low reset.
module quad_nco #(
    parameter nco_pkg::nco_mode_e MODE = nco_pkg::NCO_FULL,
    parameter bit DITHER_EN = 1'b0,
    parameter int PHASE_W   = 32,
    parameter int ADDR_W    = 10,
    parameter int SAMPLE_W  = 8,
    parameter int DITHER_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  freq_valid,
    input  logic [PHASE_W-1:0]    freq_data,
    input  logic                  offs_valid,
    input  logic [PHASE_W-1:0]    offs_data,
    output logic                  out_valid,
    output logic [2*SAMPLE_W-1:0] out_data,
    output logic                  phase_out_valid,
    output logic [PHASE_W-1:0]    phase_out_data
);

    localparam int  LAT     = 3;
    localparam bit  HAS_ACC = (MODE != nco_pkg::NCO_TABLE_ONLY);
    localparam bit  HAS_LUT = (MODE != nco_pkg::NCO_PHASE_ONLY);

    logic [PHASE_W-1:0] acc;
    logic [ADDR_W-1:0]  addr;
    logic [LAT-1:0]     vld_sr;

    nco_phase_acc #(
        .PHASE_W   (PHASE_W),
        .ADDR_W    (ADDR_W),
        .DITHER_W  (DITHER_W),
        .USE_ACC   (HAS_ACC),
        .DITHER_EN (DITHER_EN)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .freq_valid (freq_valid),
        .freq_data  (freq_data),
        .offs_valid (offs_valid),
        .offs_data  (offs_data),
        .acc_o      (acc),
        .addr_o     (addr)
    );

    // Valid pipeline: fills with ones after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_sr <= '0;
        end else begin
            vld_sr <= {vld_sr[LAT-2:0], 1'b1};
        end
    end

    if (HAS_LUT) begin : g_lut
        nco_sincos_lut #(
            .ADDR_W   (ADDR_W),
            .SAMPLE_W (SAMPLE_W)
        ) u_lut (
            .clk      (clk),
            .rst_n    (rst_n),
            .addr_i   (addr),
            .sample_o (out_data)
        );
        assign out_valid = vld_sr[LAT-1];
    end else begin : g_no_lut
        assign out_data  = '0;
        assign out_valid = 1'b0;
    end

    if (HAS_ACC) begin : g_phase_out
        assign phase_out_data  = acc;
        assign phase_out_valid = vld_sr[0];
    end else begin : g_no_phase_out
        assign phase_out_data  = '0;
        assign phase_out_valid = 1'b0;
    end

endmodule

// File: rtl/nco_chk.sv
// Module: property checker bound to quad_nco; observes ports only.
module nco_chk #(
    parameter nco_pkg::nco_mode_e MODE = nco_pkg::NCO_FULL,
    parameter int PHASE_W  = 32,
    parameter int SAMPLE_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  freq_valid,
    input logic [PHASE_W-1:0]    freq_data,
    input logic                  out_valid,
    input logic [2*SAMPLE_W-1:0] out_data,
    input logic                  phase_out_valid,
    input logic [PHASE_W-1:0]    phase_out_data
);

    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !phase_out_valid && out_data == '0 && phase_out_data == '0));

    // R5
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);

    // R9
    no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[2*SAMPLE_W-1:SAMPLE_W] != MOST_NEG && out_data[SAMPLE_W-1:0] != MOST_NEG));

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_valid && phase_out_valid) |=> ##1
        ((phase_out_data - $past(phase_out_data)) == $past(freq_data, 2)));

    if (MODE == nco_pkg::NCO_PHASE_ONLY) begin : g_pg
        // R6
        no_samples_chk: assert property (@(posedge clk) disable iff (!rst_n)
            phase_out_valid |-> !out_valid);
    end

    if (MODE == nco_pkg::NCO_TABLE_ONLY) begin : g_tl
        // R7
        no_phase_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> !phase_out_valid);
    end

endmodule

bind quad_nco nco_chk #(
    .MODE     (MODE),
    .PHASE_W  (PHASE_W),
    .SAMPLE_W (SAMPLE_W)
) u_nco_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .freq_valid      (freq_valid),
    .freq_data       (freq_data),
    .out_valid       (out_valid),
    .out_data        (out_data),
    .phase_out_valid (phase_out_valid),
    .phase_out_data  (phase_out_data)
);

// File: tb/tb_quad_nco.sv
module tb_quad_nco;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fv = 1'b0;
    logic [31:0] fd = '0;
    logic        ov = 1'b0;
    logic [31:0] od = '0;
    logic        dov = 1'b0;
    logic [31:0] dod = '0;

    always #5 clk = ~clk;

    logic        f_ov, p_ov, t_ov, d_ov;
    logic [15:0] f_od, p_od, t_od, d_od;
    logic        f_pv, p_pv, t_pv, d_pv;
    logic [31:0] f_pd, p_pd, t_pd, d_pd;

    quad_nco dut (.clk(clk), .rst_n(rst_n), .freq_valid(fv), .freq_data(fd),
        .offs_valid(ov), .offs_data(od), .out_valid(f_ov), .out_data(f_od),
        .phase_out_valid(f_pv), .phase_out_data(f_pd));

    quad_nco #(.MODE(nco_pkg::NCO_PHASE_ONLY)) dut_pg (.clk(clk), .rst_n(rst_n),
        .freq_valid(fv), .freq_data(fd), .offs_valid(ov), .offs_data(od),
        .out_valid(p_ov), .out_data(p_od), .phase_out_valid(p_pv), .phase_out_data(p_pd));

    quad_nco #(.MODE(nco_pkg::NCO_TABLE_ONLY)) dut_tl (.clk(clk), .rst_n(rst_n),
        .freq_valid(fv), .freq_data(fd), .offs_valid(ov), .offs_data(od),
        .out_valid(t_ov), .out_data(t_od), .phase_out_valid(t_pv), .phase_out_data(t_pd));

    quad_nco #(.DITHER_EN(1'b1)) dut_dt (.clk(clk), .rst_n(rst_n),
        .freq_valid(1'b0), .freq_data(32'h0), .offs_valid(dov), .offs_data(dod),
        .out_valid(d_ov), .out_data(d_od), .phase_out_valid(d_pv), .phase_out_data(d_pd));

    int total = 0;
    int bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Reference sine: round-half-away on 127*sin at bin centre.
    function automatic int ref_sin(input int a);
        real x;
        x = 127.0 * $sin(2.0 * 3.14159265358979323846 * (real'(a) + 0.5) / 1024.0);
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    function automatic logic [15:0] pack(input int a);
        return {8'(ref_sin(a)), 8'(ref_sin((a + 256) % 1024))};
    endfunction

    // Behavioural model, advanced on each rising edge.
    logic [31:0] m_fw, m_off, m_acc;
    logic [15:0] m_exp, t_exp;
    int          m_q[$];
    int          t_q[$];
    int          edges = 0;
    bit          m_rst = 1'b1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fw = '0; m_off = '0; m_acc = '0;
            m_q = {0}; t_q = {0};
            m_exp = '0; t_exp = '0;
            edges = 0; m_rst = 1'b1;
        end else begin
            m_rst = 1'b0;
            m_exp = pack(m_q.pop_front());
            m_q.push_back(int'((m_acc + m_off) >> 22));
            t_exp = pack(t_q.pop_front());
            t_q.push_back(int'(m_off >> 22));
            m_acc = m_acc + m_fw;
            if (fv) m_fw = fd;
            if (ov) m_off = od;
            if (edges < 100) edges++;
        end
    end

    bit d_ready = 1'b0;
    int d_lo = 0;
    int d_hi = 0;
    bit started = 1'b0;

    // Compare every output away from the rising edge.
    always @(negedge clk) begin
        if (started) begin
            if (m_rst) begin
                chk("R1 full valid", {30'd0, f_ov, f_pv}, 32'd0);
                chk("R1 full data", {16'd0, f_od}, 32'd0);
                chk("R1 phase data", f_pd, 32'd0);
            end else begin
                chk("R5 full out_valid", {31'd0, f_ov}, {31'd0, edges >= 3});
                chk("R3 R4 full sample", {16'd0, f_od}, {16'd0, m_exp});
                chk("R2 phase valid", {31'd0, f_pv}, {31'd0, edges >= 1});
                chk("R2 phase data", f_pd, m_acc);
                if (f_ov) chk("R9 no 0x80", {30'd0, f_od[15:8] == 8'h80, f_od[7:0] == 8'h80}, 32'd0);
                chk("R6 pg samples", {15'd0, p_ov, p_od}, 32'd0);
                chk("R6 pg phase", p_pd, m_acc);
                chk("R6 pg phase valid", {31'd0, p_pv}, {31'd0, edges >= 1});
                chk("R7 tl out_valid", {31'd0, t_ov}, {31'd0, edges >= 3});
                chk("R7 tl sample", {16'd0, t_od}, {16'd0, t_exp});
                chk("R7 tl phase stream", {t_pv, t_pd[30:0]}, 32'd0);
            end
            if (d_ready) begin
                chk("R8 dither sample in {a,a+1}",
                    {31'd0, (d_od == pack(5)) || (d_od == pack(6))}, 32'd1);
                if (d_od == pack(5)) d_lo++;
                if (d_od == pack(6)) d_hi++;
                chk("R8 dither phase stream", d_pd, 32'd0);
                chk("R8 dither valid", {31'd0, d_ov}, 32'd1);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_freq(input logic [31:0] d);
        fv = 1'b1; fd = d; tick(1); fv = 1'b0;
    endtask

    task automatic wr_offs(input logic [31:0] d);
        ov = 1'b1; od = d; tick(1); ov = 1'b0;
    endtask

    task automatic dith_setup();
        dov = 1'b1; dod = (32'd5 << 22) | 32'h0030_0000;
        tick(1); dov = 1'b0;
        tick(4); d_ready = 1'b1;
    endtask

    initial begin
        tick(1);
        started = 1'b1;
        tick(3);
        rst_n = 1'b1;
        dith_setup();
        wr_freq(32'h0000_A7C5);
        tick(40);
        wr_offs(32'h4000_0000);
        tick(20);
        wr_freq(32'h0006_8DB8);
        tick(20);
        fv = 1'b1; fd = 32'h1000_0003; ov = 1'b1; od = 32'h1234_5678;
        tick(1); fv = 1'b0; ov = 1'b0;
        tick(200);
        // R2 R3: strobes low, data toggling; held words must not change.
        for (int i = 0; i < 30; i++) begin
            fd = 32'hDEAD_0000 + 32'(i * 977);
            od = 32'hBEEF_0000 + 32'(i * 131);
            tick(1);
        end
        wr_freq(32'h8000_0000);
        tick(20);
        wr_freq(32'hFFFF_FFFF);
        tick(20);
        wr_freq(32'h0);
        // R4 R7: sweep every table address through the offset stream.
        for (int i = 0; i < 1024; i++) begin
            ov = 1'b1;
            od = (32'(i) << 22) | ((32'(i) * 32'd37) & 32'h003F_FFFF);
            tick(1);
        end
        ov = 1'b0;
        tick(10);
        // R1 R5: reset mid-run, valids must restart.
        d_ready = 1'b0;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        dith_setup();
        wr_freq(32'h0123_4567);
        tick(100);
        d_ready = 1'b0;
        total++;
        if (d_lo == 0 || d_hi == 0) begin
            bad++;
            $display("FAIL R8 dither coverage act lo=%0d hi=%0d exp both>0", d_lo, d_hi);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule